// File: doc/BRIEF.md
# Indexed Address Sequencer with Page-Cross Penalty

This block drives the bus cycles of an 8-bit processor for a read that uses indexed addressing. It fetches the opcode and then the address operand from program memory at the program counter. It adds an 8-bit index to the low byte of the base address and reads the operand. The first data read is speculative: it is issued with the uncorrected high byte of the base. If the low-byte sum carried, the block spends one more cycle. In that cycle it increments the high byte and reads again from the corrected address. Otherwise the first data read is final.

A second mode covers zero-page indexing. Here only one operand byte is fetched. The cycle after it is an internal add cycle, which performs a dummy read at the unindexed page-zero address. The final read then uses the base plus the index, wrapped within page zero, so this mode never pays the penalty. When the sequence ends, a one-cycle done pulse presents the operand together with the number of bus cycles spent. The program counter is loaded when start is accepted and is brought out.

Top module: `idx_addr_seq`

## Requirements
- R1: After a synchronous active-high reset, `bus_rd` and `done` are low and the block is idle.
- R2: After an accepted `start`, the first three read cycles address `pc_in`, `pc_in+1` and `pc_in+2` in absolute mode. In page-zero mode the first two address `pc_in` and `pc_in+1`. `pc_out` ends at `pc_in+3` (absolute) or `pc_in+2` (page zero).
- R3: In absolute mode, read cycle 4 addresses `{base_hi, (base_lo+idx) mod 256}`, where `base_lo` is the byte read in cycle 2 and `base_hi` is the byte read in cycle 3.
- R4: When `(base_lo+idx) mod 256 < idx` in absolute mode, a fifth read addresses `{(base_hi+1) mod 256, (base_lo+idx) mod 256}`. `cyc_count` then reports 5 and `op_data` is the byte read in cycle 5.
- R5: Without that carry, the access has exactly 4 read cycles. `cyc_count` reports 4 and `op_data` is the byte read in cycle 4.
- R6: In page-zero mode, cycle 3 is a dummy read at `{0x00, base}`. Cycle 4 reads `{0x00, (base+idx) mod 256}`. `cyc_count` is always 4.
- R7: `done` is high for exactly one cycle: the cycle right after the last read cycle. `op_data` and `cyc_count` are valid while it is high.
- R8: A `start` while a sequence is in progress is ignored. The bus trace and the result are those of the sequence already running.
- R9: `bus_rd` is high in every read cycle of a sequence and low otherwise, including the cycle in which `done` is high.
- R10: Absolute address arithmetic wraps at 16 bits. Base 0xFFFF with index 1 reads 0xFF00 in cycle 4 and 0x0000 in cycle 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a sequence when idle |
| zp_mode | input | 1 | 1 selects page-zero indexing, 0 selects absolute indexing; sampled with start |
| idx | input | 8 | Index value; sampled with start |
| pc_in | input | 16 | Program counter at the opcode; sampled with start |
| bus_rdata | input | 8 | Read data for the current bus address |
| bus_addr | output | 16 | Bus address, registered |
| bus_rd | output | 1 | Read strobe, registered |
| pc_out | output | 16 | Current program counter |
| done | output | 1 | One-cycle completion pulse |
| op_data | output | 8 | Operand read in the final cycle |
| cyc_count | output | 3 | Read cycles used by the last access (4 or 5) |

## Verification
The assertions assume that `bus_rdata` is valid in the same cycle as the address it answers. They also assume that reset is applied before the first sequence. Neither assumption places any condition on `start`, `idx` or the mode. The bench models memory as a combinational function of the bus address, with operand bytes placed at the fetch addresses. The random index, base, mode and PC values cover both the carry and the no-carry case. Directed cases add the 16-bit wrap, a page-zero wrap and a `start` raised while the block is busy.

// File: rtl/idx_seq_pkg.sv
package idx_seq_pkg;
  typedef enum logic [2:0] {
    S_IDLE = 3'd0,
    S_OPC  = 3'd1,
    S_LO   = 3'd2,
    S_HI   = 3'd3,
    S_RD4  = 3'd4,
    S_RD5  = 3'd5
  } seq_state_t;
endpackage

// File: rtl/idx_addr_add.sv
// Low-byte index adder with carry-out, plus a high-byte incrementer.
module idx_addr_add #(
  parameter int DW = 8
) (
  input  logic [DW-1:0] lo,
  input  logic [DW-1:0] hi,
  input  logic [DW-1:0] ix,
  output logic [DW-1:0] sum_lo,
  output logic          carry,
  output logic [DW-1:0] hi_inc
);
  logic [DW:0] wide;

  always_comb begin
    wide   = {1'b0, lo} + {1'b0, ix};
    sum_lo = wide[DW-1:0];
    carry  = wide[DW];
    hi_inc = hi + {{(DW-1){1'b0}}, 1'b1};
  end
endmodule

// File: rtl/idx_seq_fsm.sv
module idx_seq_fsm
  import idx_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic       fix_hi,
  output seq_state_t st
);
  seq_state_t st_nx;

  always_comb begin
    st_nx = st;
    unique case (st)
      S_IDLE:  if (start) st_nx = S_OPC;
      S_OPC:   st_nx = S_LO;
      S_LO:    st_nx = S_HI;
      S_HI:    st_nx = S_RD4;
      S_RD4:   st_nx = fix_hi ? S_RD5 : S_IDLE;
      S_RD5:   st_nx = S_IDLE;
      default: st_nx = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) st <= S_IDLE;
    else     st <= st_nx;
  end

  // R8
  busy_start_chk: assert property (@(posedge clk) disable iff (rst)
    (st != S_IDLE) |=> (st != S_OPC));
endmodule

// File: rtl/idx_addr_seq.sv
module idx_addr_seq
  import idx_seq_pkg::*;
#(
  parameter int DW = 8,
  parameter int CW = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              zp_mode,
  input  logic [DW-1:0]     idx,
  input  logic [2*DW-1:0]   pc_in,
  input  logic [DW-1:0]     bus_rdata,
  output logic [2*DW-1:0]   bus_addr,
  output logic              bus_rd,
  output logic [2*DW-1:0]   pc_out,
  output logic              done,
  output logic [DW-1:0]     op_data,
  output logic [CW-1:0]     cyc_count
);
  localparam int AW = 2 * DW;
  localparam logic [AW-1:0] ONE = AW'(1);
  localparam logic [CW-1:0] CONE = CW'(1);

  seq_state_t    st;
  logic [AW-1:0] pc_q, addr_q;
  logic [DW-1:0] lo_q, hi_q, idx_q, data_q;
  logic          zp_q, carry_q, rd_q, done_q;
  logic [CW-1:0] cnt_q, cyc_q;

  logic [DW-1:0] sum_lo, hi_inc;
  logic          carry;

  idx_addr_add #(.DW(DW)) u_add (
    .lo     (lo_q),
    .hi     (hi_q),
    .ix     (idx_q),
    .sum_lo (sum_lo),
    .carry  (carry),
    .hi_inc (hi_inc)
  );

  idx_seq_fsm u_fsm (
    .clk    (clk),
    .rst    (rst),
    .start  (start),
    .fix_hi (carry_q),
    .st     (st)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q    <= '0;
      addr_q  <= '0;
      lo_q    <= '0;
      hi_q    <= '0;
      idx_q   <= '0;
      zp_q    <= 1'b0;
      carry_q <= 1'b0;
      rd_q    <= 1'b0;
      done_q  <= 1'b0;
      data_q  <= '0;
      cnt_q   <= '0;
      cyc_q   <= '0;
    end else begin
      done_q <= 1'b0;
      if (st != S_IDLE) cnt_q <= cnt_q + CONE;
      unique case (st)
        S_IDLE: if (start) begin
          pc_q    <= pc_in;
          addr_q  <= pc_in;
          idx_q   <= idx;
          zp_q    <= zp_mode;
          carry_q <= 1'b0;
          rd_q    <= 1'b1;
          cnt_q   <= CONE;
        end
        S_OPC: begin
          pc_q   <= pc_q + ONE;
          addr_q <= pc_q + ONE;
        end
        S_LO: begin
          lo_q <= bus_rdata;
          pc_q <= pc_q + ONE;
          if (zp_q) addr_q <= {{DW{1'b0}}, bus_rdata};
          else      addr_q <= pc_q + ONE;
        end
        S_HI: begin
          lo_q <= sum_lo;
          if (zp_q) begin
            hi_q    <= '0;
            carry_q <= 1'b0;
            addr_q  <= {{DW{1'b0}}, sum_lo};
          end else begin
            hi_q    <= bus_rdata;
            carry_q <= carry;
            pc_q    <= pc_q + ONE;
            addr_q  <= {bus_rdata, sum_lo};
          end
        end
        S_RD4: begin
          if (carry_q) begin
            hi_q   <= hi_inc;
            addr_q <= {hi_inc, lo_q};
          end else begin
            rd_q   <= 1'b0;
            done_q <= 1'b1;
            data_q <= bus_rdata;
            cyc_q  <= cnt_q;
          end
        end
        S_RD5: begin
          rd_q   <= 1'b0;
          done_q <= 1'b1;
          data_q <= bus_rdata;
          cyc_q  <= cnt_q;
        end
        default: ;
      endcase
    end
  end

  assign bus_addr  = addr_q;
  assign bus_rd    = rd_q;
  assign pc_out    = pc_q;
  assign done      = done_q;
  assign op_data   = data_q;
  assign cyc_count = cyc_q;

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R9
  rd_off_at_done_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> !bus_rd);

  // R4
  fix_addr_chk: assert property (@(posedge clk) disable iff (rst)
    (st == S_RD5) |-> (bus_addr[AW-1:DW] == $past(bus_addr[AW-1:DW]) + 8'd1
                       && bus_addr[DW-1:0] == $past(bus_addr[DW-1:0])));

  // R6
  zp_page_chk: assert property (@(posedge clk) disable iff (rst)
    (st == S_RD4 && zp_q) |-> (bus_addr[AW-1:DW] == '0));

  // R5
  count_range_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> (cyc_count == 3'd4 || cyc_count == 3'd5));
endmodule

// File: tb/idx_addr_seq_bench.sv
module idx_addr_seq_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic        zp_mode = 1'b0;
  logic [7:0]  idx = '0;
  logic [15:0] pc_in = '0;
  logic [7:0]  bus_rdata;
  logic [15:0] bus_addr;
  logic        bus_rd;
  logic [15:0] pc_out;
  logic        done;
  logic [7:0]  op_data;
  logic [2:0]  cyc_count;

  int checks = 0;
  int errors = 0;
  int wd = 0;

  logic [15:0] m_pc;
  logic [7:0]  m_blo, m_bhi;

  always #(CLK_PERIOD/2) clk = ~clk;

  idx_addr_seq u_idx_addr_seq (
    .clk(clk), .rst(rst), .start(start), .zp_mode(zp_mode), .idx(idx),
    .pc_in(pc_in), .bus_rdata(bus_rdata), .bus_addr(bus_addr),
    .bus_rd(bus_rd), .pc_out(pc_out), .done(done), .op_data(op_data),
    .cyc_count(cyc_count)
  );

  function automatic logic [7:0] mem_f(input logic [15:0] a);
    if (a == m_pc + 16'd1) return m_blo;
    if (a == m_pc + 16'd2) return m_bhi;
    return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'h5A;
  endfunction

  always_comb bus_rdata = mem_f(bus_addr);

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic run(input logic [15:0] pc, input logic [7:0] blo,
                     input logic [7:0] bhi, input logic [7:0] ix,
                     input bit zp, input bit poke);
    logic [15:0] exp_a [5];
    logic [15:0] got_a [8];
    int n_exp, n;
    logic [7:0] s;
    bit cy, seen;
    m_pc = pc; m_blo = blo; m_bhi = bhi;
    s  = blo + ix;
    cy = !zp && (s < ix);
    exp_a[0] = pc;
    exp_a[1] = pc + 16'd1;
    if (zp) begin
      exp_a[2] = {8'h00, blo};
      exp_a[3] = {8'h00, s};
      n_exp = 4;
    end else begin
      exp_a[2] = pc + 16'd2;
      exp_a[3] = {bhi, s};
      exp_a[4] = {bhi + 8'd1, s};
      n_exp = cy ? 5 : 4;
    end
    @(negedge clk);
    start = 1'b1; pc_in = pc; idx = ix; zp_mode = zp;
    @(negedge clk);
    start = 1'b0;
    n = 0; seen = 0;
    for (int k = 0; k < 8 && !seen; k++) begin
      if (poke && k == 1) begin
        start = 1'b1; pc_in = pc ^ 16'h1234; idx = ix + 8'd7; zp_mode = !zp;
      end else start = 1'b0;
      if (done) seen = 1;
      else if (bus_rd) begin got_a[n] = bus_addr; n++; end
      if (!seen) @(negedge clk);
    end
    start = 1'b0;
    chk(seen, "R7", "done seen", 32'(seen), 1);
    chk(n == n_exp, cy ? "R4" : (zp ? "R6" : "R5"), "read cycles", n, n_exp);
    for (int k = 0; k < n_exp && k < n; k++)
      chk(got_a[k] == exp_a[k], k < 3 ? (zp && k == 2 ? "R6" : "R2") : (zp ? "R6" : (k == 3 ? "R3" : "R4")),
          "bus address", got_a[k], exp_a[k]);
    chk(cyc_count == 3'(n_exp), "R5", "cyc_count", cyc_count, n_exp);
    chk(op_data == mem_f(exp_a[n_exp-1]), "R7", "op_data", op_data, mem_f(exp_a[n_exp-1]));
    chk(pc_out == pc + (zp ? 16'd2 : 16'd3), "R2", "pc_out", pc_out, pc + (zp ? 16'd2 : 16'd3));
    chk(!bus_rd, "R9", "bus_rd at done", bus_rd, 0);
    @(negedge clk);
    chk(!done, "R7", "done width", done, 0);
    chk(!bus_rd, poke ? "R8" : "R9", "idle after done", bus_rd, 0);
  endtask

  initial begin
    int seed;
    seed = 32'h1A2B;
    void'($urandom(seed));
    m_pc = '0; m_blo = '0; m_bhi = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!bus_rd && !done, "R1", "reset state", {bus_rd, done}, 0);
    run(16'h0200, 8'hFF, 8'h00, 8'h01, 0, 0);   // R4 classic page cross -> 0x0100
    run(16'h3000, 8'hFF, 8'hFF, 8'h01, 0, 0);   // R10 wrap to 0x0000
    run(16'h4000, 8'h10, 8'h20, 8'h00, 0, 0);   // R5 zero index
    run(16'h5000, 8'hFF, 8'h00, 8'h01, 1, 0);   // R6 page-zero wrap, no penalty
    run(16'hFFFE, 8'h80, 8'h12, 8'h80, 0, 0);   // R2 PC wrap, carry
    run(16'h6000, 8'h40, 8'h55, 8'h05, 0, 1);   // R8 start while busy
    run(16'h7000, 8'hF0, 8'h10, 8'hF0, 1, 1);   // R8 page-zero with poke
    for (int i = 0; i < 60; i++)
      run(16'($urandom), 8'($urandom), 8'($urandom), 8'($urandom), 1'($urandom), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  always @(posedge clk) begin
    wd++;
    if (wd > 20000) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", wd, 20000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule